// File: doc/BRIEF.md
# Dual-Queue Host Messaging Unit

The block carries short messages between a host register bus and an embedded engine. Each direction has its own small queue. The host uses one shared data register for both queues. A host write to that register pushes a word toward the engine, on the inbound queue. A host read of the same register pops a word that the engine produced, from the outbound queue. A message is two 32-bit words written back to back. The sender first checks that the inbound queue is empty. It then polls until the queue has drained again, which confirms delivery, and gives up after a bounded number of polls.

Besides the data register the host sees three more registers. The status register shows the level flags of both queues, the interrupt causes and a sticky overflow flag. The control register holds the interrupt enables and the queue write enables. The mailbox register is written by the engine. The host can only return it to its reset pattern 0x0000F0F0. On the engine side the block offers a plain pop port for inbound words and a plain push port for outbound words.

Each queue is controlled by a three-state machine: `FS_EMPTY`, `FS_PART` and `FS_FULL`. The transitions are:
- fill: `FS_EMPTY`→`FS_PART` on an accepted push.
- top-up: `FS_PART`→`FS_FULL` on a push that takes the count to the depth.
- drain: `FS_PART`→`FS_EMPTY` on a pop of the last word.
- release: `FS_FULL`→`FS_PART` on any pop.

A push is refused while the queue is in `FS_FULL`, and a pop is refused while it is in `FS_EMPTY`.

Top module: `msgu_top`

## Requirements
- R1: After reset the status register (address 1) reads 0x00060000, meaning both not-full flags are set and nothing else. The control register (address 2) reads 0, the mailbox register (address 3) reads 0x0000F0F0, and `irq` and `eng_in_valid` are low.
- R2: With control bit 25 set, each host write to the data register (address 0) enters the inbound queue. The engine receives the words in write order on `eng_in_data`, qualified by `eng_in_valid`, and status bit 19 (inbound not empty) is set while words wait.
- R3: The inbound queue holds 2 words. When it is full, status bit 17 (inbound not full) is clear. A further host data write is dropped and sets the sticky overflow flag in status bit 0. That flag stays set until the host writes status with bit 0 set.
- R4: A host data write while control bit 25 is clear is dropped, and it does not set the overflow flag.
- R5: With control bit 24 set, an engine push enters the outbound queue, and host reads of address 0 return the words in push order. Status bit 16 is outbound not empty and bit 18 is outbound not full. `eng_out_ready` is low and pushes are dropped while the queue is full or bit 24 is clear.
- R6: A host read of address 0 while the outbound queue is empty returns 0 and leaves both queues unchanged.
- R7: An engine mailbox write loads the mailbox. A host write of 0x0000F0F0 to address 3 restores that value, and any other host value written there is ignored.
- R8: Status bit 21 is (inbound not full AND control bit 17). Bit 22 is (outbound not empty AND control bit 16). Bit 20 is (mailbox differs from 0x0000F0F0 AND control bit 20). Bit 23 reads 0. `irq` is the OR of bits 20 to 22.
- R9: Only control bits 16, 17, 20, 24 and 25 are stored. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on address 0) |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 mailbox |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| irq | output | 1 | Level interrupt, OR of the enabled causes |
| eng_in_pop | input | 1 | Engine takes the head inbound word |
| eng_in_data | output | 32 | Head of the inbound queue (0 when empty) |
| eng_in_valid | output | 1 | Inbound queue holds a word |
| eng_out_push | input | 1 | Engine offers an outbound word |
| eng_out_data | input | 32 | Outbound word |
| eng_out_ready | output | 1 | Outbound push would be accepted |
| eng_mbox_wr | input | 1 | Engine mailbox write strobe |
| eng_mbox_data | input | 32 | Engine mailbox value |

## Verification
The embedded properties watch several things on every cycle:
- a full queue holds its state and write pointer against a push;
- an empty queue holds against a pop;
- the state machine agrees with the occupancy count;
- the overflow flag stays set until it is cleared;
- disabled host writes leave the inbound queue as it was;
- `irq` never rises without an enable bit;
- the control register holds only its defined bits.

Word ordering through each queue, the exact status words and the mailbox reset-pattern rule can only be shown by the bench's scenarios. The same holds for the dropping of a third word and the behaviour of a synchronous reset that arrives with data in flight.

// File: rtl/msgu_pkg.sv
package msgu_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_MBOX = 2'd3;

    // status bit positions (decoded by host software)
    localparam int S_OVF     = 0;
    localparam int S_OUT_NE  = 16;
    localparam int S_IN_NF   = 17;
    localparam int S_OUT_NF  = 18;
    localparam int S_IN_NE   = 19;
    localparam int S_MB_INT  = 20;
    localparam int S_IN_INT  = 21;
    localparam int S_OUT_INT = 22;

    // control bit positions
    localparam int C_OUT_IE  = 16;
    localparam int C_IN_IE   = 17;
    localparam int C_MB_IE   = 20;
    localparam int C_OUT_EN  = 24;
    localparam int C_IN_EN   = 25;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << C_OUT_IE) | (REG_W'(1) << C_IN_IE) | (REG_W'(1) << C_MB_IE) |
        (REG_W'(1) << C_OUT_EN) | (REG_W'(1) << C_IN_EN);

    localparam logic [REG_W-1:0] MBOX_IDLE = 32'h0000_F0F0;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_t;

endpackage

// File: rtl/msgu_fifo.sv
module msgu_fifo
    import msgu_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fifo_state_t    state, state_nxt;
    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic [CW-1:0]  cnt;
    logic           push_ok, pop_ok;

    assign push_ok = push && (state != FS_FULL);
    assign pop_ok  = pop  && (state != FS_EMPTY);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_EMPTY: if (push_ok) state_nxt = (DEPTH == 1) ? FS_FULL : FS_PART;
            FS_PART: begin
                if (push_ok && !pop_ok && cnt == CW'(DEPTH - 1))
                    state_nxt = FS_FULL;
                else if (pop_ok && !push_ok && cnt == CW'(1))
                    state_nxt = FS_EMPTY;
            end
            FS_FULL:  if (pop_ok) state_nxt = (DEPTH == 1) ? FS_EMPTY : FS_PART;
            default:  state_nxt = FS_EMPTY;
        endcase
    end

    // state register, pointers, count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_EMPTY;
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    // outputs
    always_comb begin
        unique case (state)
            FS_EMPTY: begin empty = 1'b1; full = 1'b0; end
            FS_FULL:  begin empty = 1'b0; full = 1'b1; end
            default:  begin empty = 1'b0; full = 1'b0; end
        endcase
        rdata = empty ? '0 : mem[rptr];
    end

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FULL && push && !pop) |=> (state == FS_FULL && $stable(wptr)));

    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_EMPTY && pop && !push) |=> (state == FS_EMPTY && $stable(rptr)));

    // R2
    state_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) == (state == FS_EMPTY)) && ((cnt == CW'(DEPTH)) == (state == FS_FULL)));

endmodule

// File: rtl/msgu_mbox.sv
module msgu_mbox
    import msgu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_wr,
    input  logic [REG_W-1:0] eng_data,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_data,
    output logic [REG_W-1:0] value
);
    logic host_restore;
    assign host_restore = host_wr && (host_data == MBOX_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n)            value <= MBOX_IDLE;
        else if (eng_wr)       value <= eng_data;
        else if (host_restore) value <= MBOX_IDLE;
    end

    // R7
    mbox_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_data == MBOX_IDLE && !eng_wr) |=> (value == MBOX_IDLE));

    // R7
    mbox_host_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_data != MBOX_IDLE && !eng_wr) |=> $stable(value));

endmodule

// File: rtl/msgu_top.sv
module msgu_top
    import msgu_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              irq,
    input  logic              eng_in_pop,
    output logic [REG_W-1:0]  eng_in_data,
    output logic              eng_in_valid,
    input  logic              eng_out_push,
    input  logic [REG_W-1:0]  eng_out_data,
    output logic              eng_out_ready,
    input  logic              eng_mbox_wr,
    input  logic [REG_W-1:0]  eng_mbox_data
);
    logic [REG_W-1:0] ctl_q, status, out_head, mbox_val;
    logic             ovf_q, ovf_clr;
    logic             in_push, in_empty, in_full;
    logic             out_push, out_pop, out_empty, out_full;
    logic             data_wr;

    assign data_wr  = host_wr && (host_addr == A_DATA);
    assign in_push  = data_wr && ctl_q[C_IN_EN];
    assign out_push = eng_out_push && ctl_q[C_OUT_EN];
    assign out_pop  = host_rd && (host_addr == A_DATA);
    assign ovf_clr  = host_wr && (host_addr == A_STAT) && host_wdata[S_OVF];

    msgu_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_push), .wdata(host_wdata),
        .pop(eng_in_pop), .rdata(eng_in_data),
        .empty(in_empty), .full(in_full)
    );

    msgu_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .wdata(eng_out_data),
        .pop(out_pop), .rdata(out_head),
        .empty(out_empty), .full(out_full)
    );

    msgu_mbox u_mbox (
        .clk(clk), .rst_n(rst_n),
        .eng_wr(eng_mbox_wr), .eng_data(eng_mbox_data),
        .host_wr(host_wr && (host_addr == A_MBOX)), .host_data(host_wdata),
        .value(mbox_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (host_wr && host_addr == A_CTRL) ctl_q <= host_wdata & CTRL_MASK;
            if (in_push && in_full) ovf_q <= 1'b1;
            else if (ovf_clr)       ovf_q <= 1'b0;
        end
    end

    always_comb begin
        status            = '0;
        status[S_OVF]     = ovf_q;
        status[S_OUT_NE]  = !out_empty;
        status[S_IN_NF]   = !in_full;
        status[S_OUT_NF]  = !out_full;
        status[S_IN_NE]   = !in_empty;
        status[S_MB_INT]  = (mbox_val != MBOX_IDLE) && ctl_q[C_MB_IE];
        status[S_IN_INT]  = !in_full && ctl_q[C_IN_IE];
        status[S_OUT_INT] = !out_empty && ctl_q[C_OUT_IE];
    end

    always_comb begin
        unique case (host_addr)
            A_DATA:  host_rdata = out_head;
            A_STAT:  host_rdata = status;
            A_CTRL:  host_rdata = ctl_q;
            default: host_rdata = mbox_val;
        endcase
    end

    assign irq           = status[S_MB_INT] | status[S_IN_INT] | status[S_OUT_INT];
    assign eng_in_valid  = !in_empty;
    assign eng_out_ready = !out_full && ctl_q[C_OUT_EN];

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R4
    in_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctl_q[C_IN_EN] && !eng_in_pop) |=>
            ($stable(in_empty) && $stable(in_full) && $stable(ovf_q)));

    // R8
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_q[C_OUT_IE] || ctl_q[C_IN_IE] || ctl_q[C_MB_IE]));

    // R9
    ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTRL_MASK) == '0);

endmodule

// File: tb/msgu_top_bench.sv
`timescale 1ns/1ps
module msgu_top_bench;

    localparam logic [2:0] OP_HW = 3'd0;  // host write
    localparam logic [2:0] OP_HR = 3'd1;  // host read and compare
    localparam logic [2:0] OP_EP = 3'd2;  // engine push
    localparam logic [2:0] OP_EC = 3'd3;  // engine pop and compare
    localparam logic [2:0] OP_MB = 3'd4;  // engine mailbox write

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{OP_HR, 2'd1, 32'h0, 32'h0006_0000, 4'd1},        // 1  R1 status after reset
        '{OP_HR, 2'd2, 32'h0, 32'h0000_0000, 4'd1},        // 2  R1 control
        '{OP_HR, 2'd3, 32'h0, 32'h0000_F0F0, 4'd1},        // 3  R1 mailbox
        '{OP_HW, 2'd0, 32'h11, 32'h0, 4'd4},               // 4  R4 write while disabled
        '{OP_HR, 2'd1, 32'h0, 32'h0006_0000, 4'd4},        // 5  R4 no word, no overflow
        '{OP_HW, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd9},        // 6  R9 all ones to control
        '{OP_HR, 2'd2, 32'h0, 32'h0313_0000, 4'd9},        // 7  R9 masked readback
        '{OP_HR, 2'd1, 32'h0, 32'h0026_0000, 4'd8},        // 8  R8 inbound interrupt
        '{OP_HW, 2'd0, 32'hA1, 32'h0, 4'd2},               // 9  R2 first word
        '{OP_HR, 2'd1, 32'h0, 32'h002E_0000, 4'd2},        // 10 R2 in not empty
        '{OP_HW, 2'd0, 32'hA2, 32'h0, 4'd2},               // 11 R2 second word
        '{OP_HR, 2'd1, 32'h0, 32'h000C_0000, 4'd3},        // 12 R3 inbound full
        '{OP_HW, 2'd0, 32'hA3, 32'h0, 4'd3},               // 13 R3 dropped word
        '{OP_HR, 2'd1, 32'h0, 32'h000C_0001, 4'd3},        // 14 R3 overflow set
        '{OP_EC, 2'd0, 32'h0, 32'h0000_00A1, 4'd2},        // 15 R2 order
        '{OP_EC, 2'd0, 32'h0, 32'h0000_00A2, 4'd3},        // 16 R3 third word gone
        '{OP_HR, 2'd1, 32'h0, 32'h0026_0001, 4'd3},        // 17 R3 flag sticky
        '{OP_HW, 2'd1, 32'h1, 32'h0, 4'd3},                // 18 R3 clear flag
        '{OP_HR, 2'd1, 32'h0, 32'h0026_0000, 4'd3},        // 19 R3 flag cleared
        '{OP_HR, 2'd0, 32'h0, 32'h0000_0000, 4'd6},        // 20 R6 empty read
        '{OP_EP, 2'd0, 32'hB1, 32'h0, 4'd5},               // 21 R5 push
        '{OP_HR, 2'd1, 32'h0, 32'h0067_0000, 4'd5},        // 22 R5 out not empty
        '{OP_EP, 2'd0, 32'hB2, 32'h0, 4'd5},               // 23 R5 push
        '{OP_EP, 2'd0, 32'hB3, 32'h0, 4'd5},               // 24 R5 dropped when full
        '{OP_HR, 2'd1, 32'h0, 32'h0063_0000, 4'd5},        // 25 R5 out full
        '{OP_HR, 2'd0, 32'h0, 32'h0000_00B1, 4'd5},        // 26 R5 order
        '{OP_HR, 2'd0, 32'h0, 32'h0000_00B2, 4'd5},        // 27 R5 order
        '{OP_HR, 2'd0, 32'h0, 32'h0000_0000, 4'd6},        // 28 R6 empty again
        '{OP_HR, 2'd1, 32'h0, 32'h0026_0000, 4'd6},        // 29 R6 unchanged
        '{OP_HW, 2'd3, 32'h1234, 32'h0, 4'd7},             // 30 R7 ignored value
        '{OP_HR, 2'd3, 32'h0, 32'h0000_F0F0, 4'd7},        // 31 R7
        '{OP_MB, 2'd0, 32'hCAFE, 32'h0, 4'd7},             // 32 R7 engine write
        '{OP_HR, 2'd3, 32'h0, 32'h0000_CAFE, 4'd7},        // 33 R7
        '{OP_HR, 2'd1, 32'h0, 32'h0036_0000, 4'd8},        // 34 R8 mailbox interrupt
        '{OP_HW, 2'd3, 32'h0000_F0F0, 32'h0, 4'd7},        // 35 R7 restore
        '{OP_HR, 2'd3, 32'h0, 32'h0000_F0F0, 4'd7},        // 36 R7
        '{OP_HR, 2'd1, 32'h0, 32'h0026_0000, 4'd8}         // 37 R8 mailbox interrupt gone
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        irq;
    logic        eng_in_pop = 1'b0;
    logic [31:0] eng_in_data;
    logic        eng_in_valid;
    logic        eng_out_push = 1'b0;
    logic [31:0] eng_out_data = '0;
    logic        eng_out_ready;
    logic        eng_mbox_wr = 1'b0;
    logic [31:0] eng_mbox_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    msgu_top u_msgu_top (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .eng_in_pop(eng_in_pop), .eng_in_data(eng_in_data), .eng_in_valid(eng_in_valid),
        .eng_out_push(eng_out_push), .eng_out_data(eng_out_data),
        .eng_out_ready(eng_out_ready),
        .eng_mbox_wr(eng_mbox_wr), .eng_mbox_data(eng_mbox_data)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 check(req, host_rdata, e, "host read");
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk);
        eng_out_data = d; eng_out_push = 1'b1;
        @(posedge clk); #1;
        eng_out_push = 1'b0;
    endtask

    task automatic eng_pop(input logic [31:0] e, input int req);
        @(negedge clk);
        eng_in_pop = 1'b1;
        #1 check(req, {31'd0, eng_in_valid}, 32'd1, "engine valid");
        check(req, eng_in_data, e, "engine data");
        @(posedge clk); #1;
        eng_in_pop = 1'b0;
    endtask

    task automatic mbox_write(input logic [31:0] d);
        @(negedge clk);
        eng_mbox_data = d; eng_mbox_wr = 1'b1;
        @(posedge clk); #1;
        eng_mbox_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 ports after reset
        @(negedge clk);
        check(1, {30'd0, irq, eng_in_valid}, 32'd0, "irq and valid after reset");

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_HW:   host_write(VECS[i].addr, VECS[i].data);
                OP_HR:   host_read(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
                OP_EP:   eng_push(VECS[i].data);
                OP_EC:   eng_pop(VECS[i].exp, int'(VECS[i].req));
                default: mbox_write(VECS[i].data);
            endcase
        end

        // R5 outbound disabled: ready low and push dropped
        host_write(2'd2, 32'h0002_0000);
        @(negedge clk);
        check(5, {31'd0, eng_out_ready}, 32'd0, "ready with out disabled");
        eng_push(32'hC1);
        host_read(2'd1, 32'h0026_0000, 5);
        host_read(2'd0, 32'h0, 5);
        // R8 irq level follows enabled cause
        @(negedge clk);
        check(8, {31'd0, irq}, 32'd1, "irq with inbound enable");
        host_write(2'd2, 32'h0);
        @(negedge clk);
        check(8, {31'd0, irq}, 32'd0, "irq with no enables");

        // R1 reset with data in flight
        host_write(2'd2, 32'h0300_0000);
        host_write(2'd0, 32'h55);
        eng_push(32'h66);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        host_read(2'd1, 32'h0006_0000, 1);
        host_read(2'd2, 32'h0, 1);
        @(negedge clk);
        check(1, {31'd0, eng_in_valid}, 32'd0, "valid after mid-run reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule